// File: doc/BRIEF.md
# Real-Mode Segment Address Generator

This block turns a 16-bit offset into a 20-bit physical address in the way a 16-bit real-mode processor does. The segment value is shifted left by four bits and the offset is added to it. It holds four segment registers: code, stack, data and extra. A write port loads them one at a time. On reset the code segment holds 0xFFFF, so that a fetch at offset 0 lands at 0xFFFF0.

For each request the block chooses a segment. By default the choice comes from the access type and from whether the base register is the stack or frame pointer. A segment override can replace that default. A far access brings its own full 16-bit segment value and bypasses the register file. The resulting address and a code naming the segment used are registered, and they appear one clock after the request together with a valid flag.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals segment value times 16 plus the zero-extended offset, truncated to 20 bits, so a carry out of bit 19 is dropped and the address wraps modulo 1 MB.
- R2: An access of kind 0 (fetch) with no override and no far flag uses the code segment and reports `seg_used` = 1.
- R3: A data access (kind 1 or 3) with `req_stack_base` set and no override or far flag uses the stack segment and reports `seg_used` = 2.
- R4: A data access (kind 1 or 3) with `req_stack_base` clear and no override or far flag uses the data segment and reports `seg_used` = 3.
- R5: A string-destination access (kind 2) without the far flag always uses the extra segment and reports `seg_used` = 0. Both `req_ovr_en` and `req_stack_base` have no effect on it.
- R6: For kinds 0, 1 and 3, `req_ovr_en` = 1 without far selects the register named by `req_ovr_sel`. The encoding is 0 extra, 1 code, 2 stack, 3 data, and `seg_used` reports that same code.
- R7: `req_far_en` = 1 uses `req_far_seg` in place of any register for every access kind and reports `seg_used` = 4.
- R8: `addr_valid` is high exactly one cycle after a cycle with `req_valid` high. When no request is made, `phys_addr` and `seg_used` hold their previous values.
- R9: A write (`wr_en`, `wr_sel` with the selector encoding of R6, `wr_data`) made in the same cycle as a request does not affect that request. It applies from the next request onward.
- R10: After synchronous reset, `addr_valid`, `phys_addr` and `seg_used` are 0. The code segment is 0xFFFF and the other three segments are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Segment register write enable |
| wr_sel | input | 2 | Segment register to write (0 extra, 1 code, 2 stack, 3 data) |
| wr_data | input | 16 | Value to load |
| req_valid | input | 1 | Address request present |
| req_kind | input | 2 | Access kind: 0 fetch, 1 data, 2 string destination, 3 data |
| req_stack_base | input | 1 | Data access is based on the stack or frame pointer |
| req_ovr_en | input | 1 | Segment override requested |
| req_ovr_sel | input | 2 | Override segment selector |
| req_far_en | input | 1 | Far access with explicit segment |
| req_far_seg | input | 16 | Explicit segment of a far access |
| req_offset | input | 16 | Offset within the segment |
| addr_valid | output | 1 | Registered address is valid |
| phys_addr | output | 20 | Registered physical address |
| seg_used | output | 3 | Segment used: 0 extra, 1 code, 2 stack, 3 data, 4 far |

## Verification
A segment register write and an address request that reads the same register can arrive in the same cycle. The read must see the old value. Directed steps provoke this by writing the data and stack segments while requesting through them. The random phase also raises a write in about a third of its cycles, independently of the request. A bench model applies each write only after it has computed the expected address for that cycle, and every registered address is compared with that prediction.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;

    localparam int SEG_W  = 16;
    localparam int OFF_W  = 16;
    localparam int SHIFT  = 4;
    localparam int NSEG   = 4;
    localparam int SEL_W  = $clog2(NSEG);
    localparam int PA_W   = SEG_W + SHIFT;
    localparam int USED_W = SEL_W + 1;

    typedef enum logic [SEL_W-1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_sel_e;

    typedef enum logic [USED_W-1:0] {
        USE_ES  = 3'd0,
        USE_CS  = 3'd1,
        USE_SS  = 3'd2,
        USE_DS  = 3'd3,
        USE_FAR = 3'd4
    } seg_use_e;

    typedef enum logic [1:0] {
        ACC_FETCH  = 2'd0,
        ACC_DATA   = 2'd1,
        ACC_STRDST = 2'd2,
        ACC_DATA2  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic             valid;
        acc_kind_e        kind;
        logic             stack_base;
        logic             ovr_en;
        seg_sel_e         ovr_sel;
        logic             far_en;
        logic [SEG_W-1:0] far_seg;
        logic [OFF_W-1:0] offset;
    } addr_req_t;

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] addr;
        seg_use_e        used;
    } addr_rsp_t;

    function automatic logic [SEG_W-1:0] seg_reset_val(input int idx);
        return (idx == int'(SEG_CS)) ? {SEG_W{1'b1}} : {SEG_W{1'b0}};
    endfunction

    function automatic seg_sel_e default_seg(input acc_kind_e kind, input logic stack_base);
        seg_sel_e s;
        case (kind)
            ACC_FETCH:  s = SEG_CS;
            ACC_STRDST: s = SEG_ES;
            default:    s = stack_base ? SEG_SS : SEG_DS;
        endcase
        return s;
    endfunction

    function automatic logic [PA_W-1:0] phys_of(input logic [SEG_W-1:0] seg,
                                                input logic [OFF_W-1:0] off);
        logic [PA_W-1:0] base;
        logic [PA_W-1:0] ext;
        base = {seg, {SHIFT{1'b0}}};
        ext  = PA_W'(off);
        return base + ext;
    endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import segaddr_pkg::*;
#(
    parameter int N  = NSEG,
    parameter int W  = SEG_W,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  seg_q [N]
);

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                seg_q[i] <= W'(seg_reset_val(i));
            end else if (wr_en && (wr_sel == SW'(i))) begin
                seg_q[i] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/seg_select.sv
module seg_select
    import segaddr_pkg::*;
(
    input  addr_req_t        req,
    input  logic [SEG_W-1:0] seg_q [NSEG],
    output logic [SEG_W-1:0] seg_val,
    output seg_use_e         used
);

    seg_sel_e pick;
    logic     ovr_ok;

    // string destinations ignore overrides
    assign ovr_ok = req.ovr_en && (req.kind != ACC_STRDST);

    always_comb begin
        pick = ovr_ok ? req.ovr_sel : default_seg(req.kind, req.stack_base);
        if (req.far_en) begin
            seg_val = req.far_seg;
            used    = USE_FAR;
        end else begin
            seg_val = seg_q[pick];
            used    = seg_use_e'({1'b0, pick});
        end
    end

endmodule

// File: rtl/addr_adder.sv
module addr_adder
    import segaddr_pkg::*;
(
    input  logic [SEG_W-1:0] seg_val,
    input  logic [OFF_W-1:0] offset,
    output logic [PA_W-1:0]  phys
);

    assign phys = phys_of(seg_val, offset);

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import segaddr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [SEG_W-1:0]  wr_data,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_stack_base,
    input  logic              req_ovr_en,
    input  logic [SEL_W-1:0]  req_ovr_sel,
    input  logic              req_far_en,
    input  logic [SEG_W-1:0]  req_far_seg,
    input  logic [OFF_W-1:0]  req_offset,
    output logic              addr_valid,
    output logic [PA_W-1:0]   phys_addr,
    output logic [USED_W-1:0] seg_used
);

    addr_req_t        req;
    addr_rsp_t        rsp_q;
    logic [SEG_W-1:0] seg_q [NSEG];
    logic [SEG_W-1:0] seg_val;
    seg_use_e         used_c;
    logic [PA_W-1:0]  phys_c;

    always_comb begin
        req.valid      = req_valid;
        req.kind       = acc_kind_e'(req_kind);
        req.stack_base = req_stack_base;
        req.ovr_en     = req_ovr_en;
        req.ovr_sel    = seg_sel_e'(req_ovr_sel);
        req.far_en     = req_far_en;
        req.far_seg    = req_far_seg;
        req.offset     = req_offset;
    end

    seg_regfile #(.N(NSEG), .W(SEG_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .seg_q   (seg_q)
    );

    seg_select u_sel (
        .req     (req),
        .seg_q   (seg_q),
        .seg_val (seg_val),
        .used    (used_c)
    );

    addr_adder u_add (
        .seg_val (seg_val),
        .offset  (req.offset),
        .phys    (phys_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '{valid: 1'b0, addr: '0, used: USE_ES};
        end else begin
            rsp_q.valid <= req.valid;
            if (req.valid) begin
                rsp_q.addr <= phys_c;
                rsp_q.used <= used_c;
            end
        end
    end

    assign addr_valid = rsp_q.valid;
    assign phys_addr  = rsp_q.addr;
    assign seg_used   = rsp_q.used;

endmodule

// File: rtl/segaddr_chk.sv
module segaddr_chk
    import segaddr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic              req_stack_base,
    input logic              req_ovr_en,
    input logic              req_far_en,
    input logic [SEG_W-1:0]  req_far_seg,
    input logic [OFF_W-1:0]  req_offset,
    input logic              addr_valid,
    input logic [PA_W-1:0]   phys_addr,
    input logic [USED_W-1:0] seg_used
);

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> addr_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!addr_valid && $stable(phys_addr) && $stable(seg_used)));

    // R7
    far_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_far_en) |=>
            (seg_used == USED_W'(4) &&
             phys_addr == PA_W'({$past(req_far_seg), 4'h0} + {4'h0, $past(req_offset)})));

    // R2
    fetch_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_far_en && !req_ovr_en && req_kind == 2'd0) |=> seg_used == USED_W'(1));

    // R5
    strdst_es_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_far_en && req_kind == 2'd2) |=> seg_used == USED_W'(0));

    // R3
    stack_ss_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_far_en && !req_ovr_en && req_kind[0] && req_stack_base)
            |=> seg_used == USED_W'(2));

endmodule

bind seg_addr_gen segaddr_chk u_chk (.*);

// File: tb/sim_seg_addr_gen.sv
`timescale 1ns/1ps
module sim_seg_addr_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic        req_stack_base;
    logic        req_ovr_en;
    logic [1:0]  req_ovr_sel;
    logic        req_far_en;
    logic [15:0] req_far_seg;
    logic [15:0] req_offset;
    logic        addr_valid;
    logic [19:0] phys_addr;
    logic [2:0]  seg_used;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [15:0] model_seg [4];
    logic [19:0] exp_a;
    logic [2:0]  exp_u;

    always #2.5 clk = ~clk;

    seg_addr_gen u0 (.*);

    function automatic logic [19:0] calc_addr(logic [15:0] s, logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    function automatic logic [2:0] calc_used(logic [1:0] k, logic sb, logic ov,
                                             logic [1:0] os, logic fr);
        if (fr) return 3'd4;
        if (k == 2'd2) return 3'd0;
        if (ov) return {1'b0, os};
        if (k == 2'd0) return 3'd1;
        return sb ? 3'd2 : 3'd3;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one cycle at negedge, check the registered result one cycle later
    task automatic step(string tag, logic v, logic [1:0] k, logic sb, logic ov,
                        logic [1:0] os, logic fr, logic [15:0] fs, logic [15:0] off,
                        logic we, logic [1:0] ws, logic [15:0] wd);
        logic [15:0] sv;
        req_valid = v; req_kind = k; req_stack_base = sb; req_ovr_en = ov;
        req_ovr_sel = os; req_far_en = fr; req_far_seg = fs; req_offset = off;
        wr_en = we; wr_sel = ws; wr_data = wd;
        if (v) begin
            exp_u = calc_used(k, sb, ov, os, fr);
            sv = fr ? fs : model_seg[exp_u[1:0]];
            exp_a = calc_addr(sv, off);
        end
        if (we) model_seg[ws] = wd;
        @(negedge clk);
        chk({tag, " R8 valid"}, 32'(addr_valid), 32'(v));
        chk({tag, " R1 addr"}, 32'(phys_addr), 32'(exp_a));
        chk({tag, " used"}, 32'(seg_used), 32'(exp_u));
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; wr_en = 0; wr_sel = 0; wr_data = 0; req_valid = 0; req_kind = 0;
        req_stack_base = 0; req_ovr_en = 0; req_ovr_sel = 0; req_far_en = 0;
        req_far_seg = 0; req_offset = 0;
        model_seg[0] = 16'h0; model_seg[1] = 16'hFFFF; model_seg[2] = 16'h0; model_seg[3] = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10 valid", 32'(addr_valid), 0);
        chk("R10 addr", 32'(phys_addr), 0);
        chk("R10 used", 32'(seg_used), 0);
        exp_a = 20'h0; exp_u = 3'd0;
        // R10 R2 fetch from reset code segment
        step("R10 R2 fetch", 1, 2'd0, 0, 0, 0, 0, 0, 16'h0000, 0, 0, 0);
        chk("R10 reset vector", 32'(phys_addr), 32'h000FFFF0);
        // R8 idle holds
        step("R8 idle", 0, 2'd1, 0, 0, 0, 0, 0, 16'h1111, 0, 0, 0);
        // R9 write DS in same cycle as data request: old DS (0) used
        step("R9 R4 same-cycle", 1, 2'd1, 0, 0, 0, 0, 0, 16'h0010, 1, 2'd3, 16'h1234);
        chk("R9 old seg", 32'(phys_addr), 32'h00000010);
        step("R9 R4 next", 1, 2'd1, 0, 0, 0, 0, 0, 16'h0010, 0, 0, 0);
        chk("R9 new seg", 32'(phys_addr), 32'h00012350);
        // R1 wrap
        step("R1 load", 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd3, 16'hFFFF);
        step("R1 wrap", 1, 2'd3, 0, 0, 0, 0, 0, 16'hFFFF, 0, 0, 0);
        chk("R1 wrapped", 32'(phys_addr), 32'h0000FFEF);
        // R3 stack write same cycle, then stack access
        step("R9 R3 stack", 1, 2'd1, 1, 0, 0, 0, 0, 16'h0004, 1, 2'd2, 16'h2000);
        step("R3 stack", 1, 2'd3, 1, 0, 0, 0, 0, 16'h0004, 0, 0, 0);
        // R5 string destination ignores override and stack base
        step("R5 es", 1, 2'd2, 1, 1, 2'd3, 0, 0, 16'h0100, 1, 2'd0, 16'h0800);
        step("R5 es new", 1, 2'd2, 0, 1, 2'd1, 0, 0, 16'h0100, 0, 0, 0);
        // R6 override
        step("R6 ovr", 1, 2'd0, 0, 1, 2'd2, 0, 0, 16'h0042, 0, 0, 0);
        step("R6 ovr data", 1, 2'd1, 1, 1, 2'd0, 0, 0, 16'h0042, 0, 0, 0);
        // R7 far
        step("R7 far", 1, 2'd2, 1, 1, 2'd1, 1, 16'hF000, 16'hFFFF, 0, 0, 0);
        chk("R7 far addr", 32'(phys_addr), 32'h000FFFFF);
        step("R7 far wrap", 1, 2'd0, 0, 0, 0, 1, 16'hFFFF, 16'h0020, 0, 0, 0);
        chk("R7 R1 far wrap", 32'(phys_addr), 32'h00000010);
        // random phase (R1..R9)
        for (int i = 0; i < 3000; i++) begin
            logic v, sb, ov, fr, we;
            v  = ($urandom % 5) != 0;
            sb = $urandom % 2;
            ov = ($urandom % 4) == 0;
            fr = ($urandom % 6) == 0;
            we = ($urandom % 3) == 0;
            step("rand R1-mix", v, 2'($urandom), sb, ov, 2'($urandom), fr,
                 16'($urandom), 16'($urandom), we, 2'($urandom), 16'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule